// File: doc/BRIEF.md
# Double-and-Add Scalar Multiplication Sequencer

This block computes Q = k·P on an elliptic curve over GF(2^m), with points held in Jacobian projective form. It walks the scalar from its most significant bit to its least, one bit per clock. Each clock, an external combinational point unit receives the running accumulator Q and the base point P. The unit returns two results side by side: the doubled value 2Q and the sum 2Q+P.

The sequencer owns the rest of the work. It runs the start/busy/done handshake and latches the scalar and base point. It holds the accumulator bank and chooses what is written back each cycle. It also catches the two cases where the sum formula breaks down: the doubled value is the point at infinity, or the doubled value equals P. In those cases it substitutes P or 2P for the unit's sum. 2P is captured in a single setup cycle before the scan, by feeding P to the unit in place of Q.

Top module: `ec_scalar_seq`

## Requirements
- R1: After reset, busy_o and done_o are 0 and the result outputs read the point at infinity, encoded as (X,Y,Z) = (1,1,0).
- R2: A start_i pulse while idle latches key_i and the base point. busy_o then stays high for exactly M+1 cycles: one setup cycle followed by M iteration cycles that consume key bits from bit M-1 down to bit 0.
- R3: When done_o rises, the result outputs equal k·P for the latched scalar k and base point P.
- R4: A select code of 01 is raised when the doubled Z coordinate is all zeros. With a key bit of 1, the accumulator then takes P, not the unit's sum.
- R5: A select code of 10 is raised when all three doubled coordinates equal P. With a key bit of 1, the accumulator then takes the 2P value captured in the setup cycle. Code 00 passes the unit's sum, and code 01 has priority over 10.
- R6: With a key bit of 0, the accumulator takes the doubled value.
- R7: A start_i pulse while busy_o is high is ignored. The scalar, the base point and the run length are not affected.
- R8: done_o is a one-cycle pulse in the cycle after busy_o falls. The result then holds until the next accepted start.
- R9: A zero scalar yields (1,1,0), and a scalar of one yields P unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| key_i | input | M | Scalar |
| px_i | input | M | Base point X |
| py_i | input | M | Base point Y |
| pz_i | input | M | Base point Z |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle completion pulse |
| qx_o | output | M | Result X |
| qy_o | output | M | Result Y |
| qz_o | output | M | Result Z |
| pu_qx_o | output | M | Point unit operand Q, X |
| pu_qy_o | output | M | Point unit operand Q, Y |
| pu_qz_o | output | M | Point unit operand Q, Z |
| pu_px_o | output | M | Point unit operand P, X |
| pu_py_o | output | M | Point unit operand P, Y |
| pu_pz_o | output | M | Point unit operand P, Z |
| pu_dx_i | input | M | Doubled result X |
| pu_dy_i | input | M | Doubled result Y |
| pu_dz_i | input | M | Doubled result Z |
| pu_ax_i | input | M | Sum result 2Q+P, X |
| pu_ay_i | input | M | Sum result 2Q+P, Y |
| pu_az_i | input | M | Sum result 2Q+P, Z |

## Verification
Two functions can act in the same cycle. One is the special-case override, where the doubled value is infinity or equals P. The other is the key-bit choice between the doubled value and the selected sum. The first one-bit of every nonzero key meets an infinite accumulator, so it always forces the override.

A scalar of 253 in a mock group of order 251 drives the doubled value onto P exactly on a one-bit. The mock unit returns a zero point whenever the sum formula would be degenerate, so a wrong override or a wrong key-bit choice corrupts the final product. That product is compared with k·P computed arithmetically in the bench.

// File: rtl/ec_seq_pkg.sv
package ec_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} seq_state_e;
  localparam logic [1:0] SEL_SUM  = 2'b00;
  localparam logic [1:0] SEL_BASE = 2'b01;
  localparam logic [1:0] SEL_DBLP = 2'b10;
endpackage

// File: rtl/ec_seq_ctrl.sv
module ec_seq_ctrl
  import ec_seq_pkg::*;
#(
  parameter int M = 163
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] key_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         load_o,
  output logic         setup_o,
  output logic         run_o,
  output logic         bit_o
);
  localparam int CW = (M > 2) ? $clog2(M) : 1;

  seq_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic [M-1:0]    key_q;
  logic            done_q;
  logic            last;

  assign last    = (cnt_q == '0);
  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign setup_o = (state_q == ST_SETUP);
  assign run_o   = (state_q == ST_RUN);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign bit_o   = key_q[M-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      key_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= run_o && last;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          key_q   <= key_i;
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          cnt_q   <= CW'(M - 1);
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          key_q <= key_q << 1;
          if (last) state_q <= ST_IDLE;
          else      cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_setup_to_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_o |=> run_o);
  assert_run_length_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !last) |=> run_o);
  assert_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !setup_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/ec_pt_select.sv
module ec_pt_select
  import ec_seq_pkg::*;
#(
  parameter int M = 163
) (
  input  logic [M-1:0] px_i, py_i, pz_i,
  input  logic [M-1:0] p2x_i, p2y_i, p2z_i,
  input  logic [M-1:0] dx_i, dy_i, dz_i,
  input  logic [M-1:0] ax_i, ay_i, az_i,
  output logic [1:0]   sel_o,
  output logic [M-1:0] ox_o, oy_o, oz_o
);
  logic is_inf, is_p;

  assign is_inf = (dz_i == '0);
  assign is_p   = (dx_i == px_i) && (dy_i == py_i) && (dz_i == pz_i);

  always_comb begin
    if (is_inf)    sel_o = SEL_BASE;
    else if (is_p) sel_o = SEL_DBLP;
    else           sel_o = SEL_SUM;
  end

  always_comb begin
    unique case (sel_o)
      SEL_BASE: begin ox_o = px_i;  oy_o = py_i;  oz_o = pz_i;  end
      SEL_DBLP: begin ox_o = p2x_i; oy_o = p2y_i; oz_o = p2z_i; end
      default:  begin ox_o = ax_i;  oy_o = ay_i;  oz_o = az_i;  end
    endcase
  end
endmodule

// File: rtl/ec_acc_bank.sv
module ec_acc_bank #(
  parameter int M = 163
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         setup_i,
  input  logic         run_i,
  input  logic         bit_i,
  input  logic [M-1:0] px_i, py_i, pz_i,
  input  logic [M-1:0] dx_i, dy_i, dz_i,
  input  logic [M-1:0] sx_i, sy_i, sz_i,
  output logic [M-1:0] px_o, py_o, pz_o,
  output logic [M-1:0] p2x_o, p2y_o, p2z_o,
  output logic [M-1:0] qx_o, qy_o, qz_o
);
  localparam logic [M-1:0] ONE = M'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_o <= '0; py_o <= '0; pz_o <= '0;
    end else if (load_i) begin
      px_o <= px_i; py_o <= py_i; pz_o <= pz_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p2x_o <= '0; p2y_o <= '0; p2z_o <= '0;
    end else if (setup_i) begin
      p2x_o <= dx_i; p2y_o <= dy_i; p2z_o <= dz_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qx_o <= ONE; qy_o <= ONE; qz_o <= '0;
    end else if (setup_i) begin
      qx_o <= ONE; qy_o <= ONE; qz_o <= '0;
    end else if (run_i) begin
      if (bit_i) begin
        qx_o <= sx_i; qy_o <= sy_i; qz_o <= sz_i;
      end else begin
        qx_o <= dx_i; qy_o <= dy_i; qz_o <= dz_i;
      end
    end
  end

  assert_q_cleared_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> (qx_o == ONE && qy_o == ONE && qz_o == '0));
  assert_q_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!setup_i && !run_i) |=> $stable({qx_o, qy_o, qz_o}));
endmodule

// File: rtl/ec_scalar_seq.sv
module ec_scalar_seq
  import ec_seq_pkg::*;
#(
  parameter int M = 163
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] key_i,
  input  logic [M-1:0] px_i,
  input  logic [M-1:0] py_i,
  input  logic [M-1:0] pz_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [M-1:0] qx_o,
  output logic [M-1:0] qy_o,
  output logic [M-1:0] qz_o,
  output logic [M-1:0] pu_qx_o,
  output logic [M-1:0] pu_qy_o,
  output logic [M-1:0] pu_qz_o,
  output logic [M-1:0] pu_px_o,
  output logic [M-1:0] pu_py_o,
  output logic [M-1:0] pu_pz_o,
  input  logic [M-1:0] pu_dx_i,
  input  logic [M-1:0] pu_dy_i,
  input  logic [M-1:0] pu_dz_i,
  input  logic [M-1:0] pu_ax_i,
  input  logic [M-1:0] pu_ay_i,
  input  logic [M-1:0] pu_az_i
);
  logic         load, setup, run, kbit;
  logic [1:0]   sel;
  logic [M-1:0] p_x, p_y, p_z, p2_x, p2_y, p2_z;
  logic [M-1:0] s_x, s_y, s_z, q_x, q_y, q_z;

  ec_seq_ctrl #(.M(M)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .key_i,
    .busy_o, .done_o,
    .load_o(load), .setup_o(setup), .run_o(run), .bit_o(kbit)
  );

  ec_pt_select #(.M(M)) i_sel (
    .px_i(p_x), .py_i(p_y), .pz_i(p_z),
    .p2x_i(p2_x), .p2y_i(p2_y), .p2z_i(p2_z),
    .dx_i(pu_dx_i), .dy_i(pu_dy_i), .dz_i(pu_dz_i),
    .ax_i(pu_ax_i), .ay_i(pu_ay_i), .az_i(pu_az_i),
    .sel_o(sel), .ox_o(s_x), .oy_o(s_y), .oz_o(s_z)
  );

  ec_acc_bank #(.M(M)) i_acc (
    .clk_i, .rst_ni,
    .load_i(load), .setup_i(setup), .run_i(run), .bit_i(kbit),
    .px_i, .py_i, .pz_i,
    .dx_i(pu_dx_i), .dy_i(pu_dy_i), .dz_i(pu_dz_i),
    .sx_i(s_x), .sy_i(s_y), .sz_i(s_z),
    .px_o(p_x), .py_o(p_y), .pz_o(p_z),
    .p2x_o(p2_x), .p2y_o(p2_y), .p2z_o(p2_z),
    .qx_o(q_x), .qy_o(q_y), .qz_o(q_z)
  );

  // setup cycle doubles P itself to obtain 2P
  assign pu_qx_o = setup ? p_x : q_x;
  assign pu_qy_o = setup ? p_y : q_y;
  assign pu_qz_o = setup ? p_z : q_z;
  assign pu_px_o = p_x;
  assign pu_py_o = p_y;
  assign pu_pz_o = p_z;
  assign qx_o = q_x;
  assign qy_o = q_y;
  assign qz_o = q_z;

  assert_sel_base_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && kbit && pu_dz_i == '0) |=> (qx_o == p_x && qy_o == p_y && qz_o == p_z));
  assert_sel_dblp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && kbit && sel == SEL_DBLP) |=> (qx_o == p2_x && qy_o == p2_y && qz_o == p2_z));
  assert_bit_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !kbit) |=> (qx_o == $past(pu_dx_i) && qz_o == $past(pu_dz_i)));
endmodule

// File: tb/test_ec_scalar_seq.sv
module test_ec_scalar_seq;
  localparam int M = 8;
  localparam int N = 251;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [M-1:0] key = '0, px = '0, py = '0, pz = '0;
  logic busy, done;
  logic [M-1:0] qx, qy, qz, uqx, uqy, uqz, upx, upy, upz;
  logic [M-1:0] dx, dy, dz, ax, ay, az;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  ec_scalar_seq #(.M(M)) i_ec_scalar_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key),
    .px_i(px), .py_i(py), .pz_i(pz), .busy_o(busy), .done_o(done),
    .qx_o(qx), .qy_o(qy), .qz_o(qz),
    .pu_qx_o(uqx), .pu_qy_o(uqy), .pu_qz_o(uqz),
    .pu_px_o(upx), .pu_py_o(upy), .pu_pz_o(upz),
    .pu_dx_i(dx), .pu_dy_i(dy), .pu_dz_i(dz),
    .pu_ax_i(ax), .pu_ay_i(ay), .pu_az_i(az)
  );

  // mock group: integers mod N, n -> (n, n^5A, 1), 0 -> (1,1,0)
  function automatic logic [3*M-1:0] enc(input int v);
    if (v == 0) return {8'd1, 8'd1, 8'd0};
    return {v[7:0], v[7:0] ^ 8'h5A, 8'd1};
  endfunction
  function automatic int dec(input logic [M-1:0] x, input logic [M-1:0] z);
    return (z == 0) ? 0 : int'(x);
  endfunction

  always_comb begin
    int nq, np, nd;
    nq = dec(uqx, uqz);
    np = dec(upx, upz);
    nd = (2 * nq) % N;
    {dx, dy, dz} = enc(nd);
    // degenerate sum formula: garbage when 2Q is infinity or equals P
    if (nd == 0 || nd == np) {ax, ay, az} = '0;
    else {ax, ay, az} = enc((nd + np) % N);
  end

  task automatic check(input string req, input logic [3*M-1:0] act, input logic [3*M-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start a run, count busy cycles, leave at the cycle done_o is high
  task automatic run_one(input logic [7:0] k, input int n, input bit poke, output int cyc);
    {px, py, pz} = enc(n);
    key = k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      if (poke && cyc == 3) begin
        key = ~k; {px, py, pz} = enc(5); start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (cyc >= 1000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, M + 1);
    end
  endtask

  // {key, base multiple}
  localparam logic [15:0] VEC [8] = '{
    {8'd253, 8'd7},    // R5: 2Q equals P on a one bit
    {8'h80,  8'd3},    // R4 then R6 trailing zeros
    {8'hFF,  8'd200},  // R3
    {8'hA5,  8'd17},   // R3 R6 mixed
    {8'h01,  8'd99},   // R9 key one
    {8'h00,  8'd55},   // R9 key zero
    {8'h3C,  8'd250},  // R3
    {8'h7E,  8'd1}     // R3
  };

  initial begin
    int cyc;
    logic [3*M-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset result", {qx, qy, qz}, enc(0));
    check("R1 reset flags", {22'd0, busy, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      run_one(VEC[i][15:8], int'(VEC[i][7:0]), 1'b0, cyc);
      check("R2 busy length", 24'(cyc), 24'(M + 1));
      check("R3 R4 R5 R6 R9 product", {qx, qy, qz},
            enc((int'(VEC[i][15:8]) * int'(VEC[i][7:0])) % N));
      check("R8 done high", {23'd0, done}, 24'd1);
      @(negedge clk);
    end

    // R7: start while busy must not restart or change operands
    run_one(8'hC3, 45, 1'b1, cyc);
    check("R7 run length", 24'(cyc), 24'(M + 1));
    check("R7 product", {qx, qy, qz}, enc((8'hC3 * 45) % N));
    held = {qx, qy, qz};
    @(negedge clk);
    check("R8 done pulse ends", {23'd0, done}, 24'd0);
    repeat (5) @(negedge clk);
    check("R8 result held", {qx, qy, qz}, held);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule